// File: doc/BRIEF.md
# Three-Wire Serial Slave Port

This block is the slave end of a three-wire synchronous serial link made of a chip-enable line, a serial clock and one bidirectional data line. A host raises the enable with the serial clock low and shifts in a command byte, least significant bit first. The command byte selects a read or a write, one of two address spaces (clock registers or RAM) and a five-bit address. The transfer then continues with one data byte, or with a run of consecutive bytes when the address field is all ones. Dropping the enable ends the transfer at any point.

The serial pins are sampled in a faster system clock domain and edge-detected there. On the inside, the block talks to a byte-wide register/RAM port through one-cycle write and read strobes. Read data is expected on `rdata` one system clock after `rd_stb`. On the serial side, input bits are taken on rising serial-clock edges. Output bits are launched on falling edges, and the data driver is released on each rising edge.

Top module: `tws_slave`

## Requirements
- R1: After reset, and while `ce` is low, `io_oe`, `wr_stb` and `rd_stb` are all low.
- R2: The command byte arrives least significant bit first. Bit 0 set means read and clear means write. Bit 6 set selects RAM (`space`=1) and clear selects clock registers (`space`=0). Bits 5..1 carry the address, with bit 1 as the address LSB.
- R3: A command byte whose bit 7 is clear produces no strobe, and the block never drives `io_oe` for the rest of that transfer.
- R4: For a write, the eight bits after the command are taken LSB first on rising serial-clock edges. They yield exactly one `wr_stb` pulse with that byte on `wdata` and the target on `addr`/`space`.
- R5: In a single-byte write, serial-clock cycles after the data byte cause no further strobe and no change to any stored byte.
- R6: For a read, `rd_stb` fetches the byte, and its bits are driven LSB first on falling edges. The first bit appears on the falling edge that directly follows the eighth command bit.
- R7: `io_oe` goes low after every rising serial-clock edge during a read, and within a few system clocks of `ce` falling. During a read it is high after each falling edge.
- R8: In a single-byte read, extra serial-clock cycles re-send the byte at the same address.
- R9: Address 31 selects a burst that starts at address 0 and steps by one per byte, for both reads and writes. Address 31 is never presented on `addr`.
- R10: A burst wraps to address 0 after address 7 in the clock space and after address 30 in the RAM space.
- R11: Lowering `ce` part-way through a byte aborts the transfer with no strobe, and the next transfer works normally.
- R12: `wr_stb` and `rd_stb` are single-cycle pulses and never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Serial chip enable, transfer active while high |
| sclk | input | 1 | Serial clock |
| io_in | input | 1 | Data line as seen at the pad input |
| io_out | output | 1 | Data value driven onto the line |
| io_oe | output | 1 | Output enable for the data line driver |
| addr | output | 5 | Register/RAM address for the current strobe |
| space | output | 1 | 1 = RAM space, 0 = clock-register space |
| wr_stb | output | 1 | One-cycle write strobe |
| wdata | output | 8 | Write data, valid with `wr_stb` |
| rd_stb | output | 1 | One-cycle read strobe |
| rdata | input | 8 | Read data, valid one cycle after `rd_stb` |

## Verification
Single-byte writes and reads to the same address in both spaces show whether the command fields are decoded into the right space and address and in the right bit order. Writes and reads padded with extra serial clocks separate a design that ignores the surplus clocks on writes and re-sends the byte on reads from one that does neither. Long bursts in both spaces show where the address wraps. A truncated transfer and commands with the top bit clear confirm that nothing is stored or driven when the host does not complete a valid command.

// File: rtl/tws_pkg.sv
// Shared types and helpers for the three-wire serial slave.
// Assumes an 8-bit command byte: {valid, space, addr[4:0], read}.
package tws_pkg;

    localparam int CMD_W  = 8;
    localparam int ADDR_W = 5;

    typedef enum logic [2:0] {
        ST_IDLE,   // enable just seen, preparing for the command
        ST_CMD,    // shifting in the command byte
        ST_WR,     // shifting in write data
        ST_RD,     // shifting out read data
        ST_SKIP    // transfer finished or invalid, wait for enable low
    } tws_state_e;

    typedef struct packed {
        logic              valid;
        logic              ram;
        logic [ADDR_W-1:0] addr;
        logic              rd;
    } tws_cmd_t;

endpackage

// File: rtl/tws_sync.sv
// Multi-bit input synchronizer: each bit passes through STAGES flops.
// Assumes the bits are independent level signals slow compared with clk.
module tws_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        // Purpose: move the sampled value one stage along the chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain[g] <= '0;
            end else if (g == 0) begin
                chain[g] <= d_in;
            end else begin
                chain[g] <= chain[(g == 0) ? 0 : g - 1];
            end
        end
    end

    assign d_out = chain[STAGES-1];

endmodule

// File: rtl/tws_addr_step.sv
// Computes the address of the next byte in a transfer.
// A single-byte access keeps its address; a burst steps and wraps at
// the last valid address of the selected space.
module tws_addr_step #(
    parameter int ADDR_W   = 5,
    parameter int CLK_LAST = 7,
    parameter int RAM_LAST = 30
) (
    input  logic              burst,
    input  logic              ram,
    input  logic [ADDR_W-1:0] cur,
    output logic [ADDR_W-1:0] nxt
);

    localparam logic [ADDR_W-1:0] CLK_END = ADDR_W'(CLK_LAST);
    localparam logic [ADDR_W-1:0] RAM_END = ADDR_W'(RAM_LAST);

    logic [ADDR_W-1:0] last;

    // Purpose: pick the wrap point and form the following address.
    always_comb begin
        last = ram ? RAM_END : CLK_END;
        if (!burst) begin
            nxt = cur;
        end else if (cur >= last) begin
            nxt = '0;
        end else begin
            nxt = cur + 1'b1;
        end
    end

endmodule

// File: rtl/tws_ctrl.sv
// Protocol sequencer for the three-wire slave.
// Works on synchronized enable and serial-clock edge pulses. It assumes
// rdata is valid one clk after rd_stb and that at least four clk cycles
// separate a serial-clock edge from the next one.
module tws_ctrl
    import tws_pkg::*;
#(
    parameter int CLK_LAST = 7,
    parameter int RAM_LAST = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_s,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              din,
    input  logic [7:0]        rdata,
    output logic              io_out,
    output logic              io_oe,
    output logic [ADDR_W-1:0] addr,
    output logic              space,
    output logic              wr_stb,
    output logic [7:0]        wdata,
    output logic              rd_stb
);

    tws_state_e        state;
    logic [2:0]        bit_cnt;
    logic [7:0]        in_sh;
    logic [7:0]        out_sh;
    logic              burst;
    logic              load_q;
    logic [7:0]        in_byte;
    tws_cmd_t          cmd;
    logic [ADDR_W-1:0] addr_nxt;

    assign in_byte = {din, in_sh[7:1]};
    assign cmd     = tws_cmd_t'(in_byte);

    tws_addr_step #(
        .ADDR_W   (ADDR_W),
        .CLK_LAST (CLK_LAST),
        .RAM_LAST (RAM_LAST)
    ) u_step (
        .burst (burst),
        .ram   (space),
        .cur   (addr),
        .nxt   (addr_nxt)
    );

    // Purpose: sequence command, data and output-enable per serial edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            in_sh   <= '0;
            out_sh  <= '0;
            burst   <= 1'b0;
            load_q  <= 1'b0;
            io_out  <= 1'b0;
            io_oe   <= 1'b0;
            addr    <= '0;
            space   <= 1'b0;
            wr_stb  <= 1'b0;
            wdata   <= '0;
            rd_stb  <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            rd_stb <= 1'b0;
            load_q <= rd_stb;
            if (!ce_s) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
                io_oe   <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        state   <= ST_CMD;
                        bit_cnt <= '0;
                    end
                    ST_CMD: begin
                        if (sclk_rise) begin
                            in_sh   <= in_byte;
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == 3'd7) begin
                                if (!cmd.valid) begin
                                    state <= ST_SKIP;
                                end else begin
                                    space <= cmd.ram;
                                    burst <= &cmd.addr;
                                    addr  <= (&cmd.addr) ? '0 : cmd.addr;
                                    if (cmd.rd) begin
                                        state  <= ST_RD;
                                        rd_stb <= 1'b1;
                                    end else begin
                                        state <= ST_WR;
                                    end
                                end
                            end
                        end
                    end
                    ST_WR: begin
                        if (wr_stb && burst) begin
                            addr <= addr_nxt;
                        end
                        if (sclk_rise) begin
                            in_sh   <= in_byte;
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == 3'd7) begin
                                wr_stb <= 1'b1;
                                wdata  <= in_byte;
                                if (!burst) begin
                                    state <= ST_SKIP;
                                end
                            end
                        end
                    end
                    ST_RD: begin
                        if (sclk_rise) begin
                            io_oe <= 1'b0;
                        end
                        if (sclk_fall) begin
                            io_oe   <= 1'b1;
                            io_out  <= out_sh[0];
                            out_sh  <= {1'b0, out_sh[7:1]};
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == 3'd7) begin
                                addr   <= addr_nxt;
                                rd_stb <= 1'b1;
                            end
                        end
                    end
                    default: begin
                        state <= ST_SKIP;
                    end
                endcase
            end
            if (load_q) begin
                out_sh <= rdata;
            end
        end
    end

endmodule

// File: rtl/tws_slave.sv
// Top of the three-wire serial slave. Synchronizes enable, serial clock
// and data-in into clk, detects serial-clock edges and hands them to the
// sequencer. Assumes clk runs at least eight times faster than sclk.
module tws_slave #(
    parameter int SYNC_STAGES = 2,
    parameter int CLK_LAST    = 7,
    parameter int RAM_LAST    = 30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce,
    input  logic       sclk,
    input  logic       io_in,
    output logic       io_out,
    output logic       io_oe,
    output logic [4:0] addr,
    output logic       space,
    output logic       wr_stb,
    output logic [7:0] wdata,
    output logic       rd_stb,
    input  logic [7:0] rdata
);

    localparam int PIN_W = 3;

    logic [PIN_W-1:0] pins_s;
    logic             ce_s;
    logic             sclk_s;
    logic             io_s;
    logic             sclk_d;
    logic             sclk_rise;
    logic             sclk_fall;

    tws_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({ce, sclk, io_in}),
        .d_out (pins_s)
    );

    assign {ce_s, sclk_s, io_s} = pins_s;

    // Purpose: keep last synchronized serial-clock level for edge detect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
        end
    end

    assign sclk_rise = ce_s &  sclk_s & ~sclk_d;
    assign sclk_fall = ce_s & ~sclk_s &  sclk_d;

    tws_ctrl #(
        .CLK_LAST (CLK_LAST),
        .RAM_LAST (RAM_LAST)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_s      (ce_s),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .din       (io_s),
        .rdata     (rdata),
        .io_out    (io_out),
        .io_oe     (io_oe),
        .addr      (addr),
        .space     (space),
        .wr_stb    (wr_stb),
        .wdata     (wdata),
        .rd_stb    (rd_stb)
    );

endmodule

// File: rtl/tws_slave_chk.sv
// Protocol checker for tws_slave, attached with bind. Observes ports
// and the internal edge pulses that the synchronizer stage produces.
module tws_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_s,
    input logic       sclk_rise,
    input logic       sclk_fall,
    input logic       io_oe,
    input logic [4:0] addr,
    input logic       wr_stb,
    input logic       rd_stb
);

    // R12: write strobe lasts one cycle
    assert_wr_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R12: read strobe lasts one cycle
    assert_rd_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> !rd_stb);

    // R12: never both strobes at once
    assert_no_dual_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && rd_stb));

    // R7: driver released after enable drops
    assert_ce_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_s |=> !io_oe);

    // R7: driver released after each rising serial edge
    assert_rise_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |=> !io_oe);

    // R6: driver turns on only after a falling serial edge
    assert_fall_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_oe) |-> $past(sclk_fall));

    // R4: write strobe follows a rising serial edge
    assert_wr_after_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(sclk_rise));

    // R9: the burst code is never presented as an address
    assert_no_addr31_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb || rd_stb) |-> (addr != 5'd31));

endmodule

bind tws_slave tws_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_s      (ce_s),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .io_oe     (io_oe),
    .addr      (addr),
    .wr_stb    (wr_stb),
    .rd_stb    (rd_stb)
);

// File: tb/tws_slave_tb_top.sv
// Directed bench for tws_slave: one task per scenario, each checking itself.
module tws_slave_tb_top;

    localparam time HALF     = 200ns;
    localparam int  WD_LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce = 1'b0;
    logic       sclk = 1'b0;
    logic       io_in = 1'b0;
    logic       io_out;
    logic       io_oe;
    logic [4:0] addr;
    logic       space;
    logic       wr_stb;
    logic [7:0] wdata;
    logic       rd_stb;
    logic [7:0] rdata;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int strobe_bad = 0;
    int wd_cnt = 0;
    logic wr_prev = 1'b0;
    logic done = 1'b0;

    logic [7:0] clk_m   [0:31];
    logic [7:0] ram_m   [0:31];
    logic [7:0] exp_clk [0:31];
    logic [7:0] exp_ram [0:31];
    logic [7:0] rbuf    [0:39];
    logic [7:0] wbuf    [0:39];

    always #10ns clk = ~clk;

    tws_slave dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce     (ce),
        .sclk   (sclk),
        .io_in  (io_in),
        .io_out (io_out),
        .io_oe  (io_oe),
        .addr   (addr),
        .space  (space),
        .wr_stb (wr_stb),
        .wdata  (wdata),
        .rd_stb (rd_stb),
        .rdata  (rdata)
    );

    // Register/RAM port model with one-cycle read latency, plus strobe watch.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) begin
                clk_m[i] <= 8'h20 + 8'(i);
                ram_m[i] <= 8'h80 + 8'(3 * i);
            end
            rdata   <= '0;
            wr_prev <= 1'b0;
        end else begin
            if (wr_stb) begin
                if (space) ram_m[addr] <= wdata;
                else       clk_m[addr] <= wdata;
                wr_cnt <= wr_cnt + 1;
            end
            if (rd_stb) rdata <= space ? ram_m[addr] : clk_m[addr];
            if ((wr_stb && rd_stb) || (wr_stb && wr_prev)) strobe_bad <= strobe_bad + 1;
            wr_prev <= wr_stb;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        wd_cnt <= wd_cnt + 1;
        if (wd_cnt == WD_LIMIT && !done) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", wd_cnt, WD_LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [7:0] mk_cmd(input logic ram, input logic [4:0] a, input logic rd);
        return {1'b1, ram, a, rd};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    task automatic ce_up();
        sclk = 1'b0;
        #(HALF);
        ce = 1'b1;
        #(HALF);
    endtask

    task automatic ce_down();
        #(HALF);
        ce = 1'b0;
        io_in = 1'b0;
        #(2 * HALF);
    endtask

    // One serial clock: oe_hi sampled late in the high phase, rest after fall.
    task automatic clk_bit(input logic din, output logic dout, output logic oe_hi, output logic oe_lo);
        io_in = din;
        #(HALF);
        sclk = 1'b1;
        #(HALF - 20ns);
        oe_hi = io_oe;
        #20ns;
        sclk = 1'b0;
        #(HALF);
        dout  = io_out;
        oe_lo = io_oe;
    endtask

    task automatic do_read(input logic [7:0] cmd, input int nbytes,
                           output logic hi_bad, output logic lo_bad, output logic any_oe);
        logic b, oh, ol;
        hi_bad = 1'b0; lo_bad = 1'b0; any_oe = 1'b0;
        ce_up();
        for (int i = 0; i < 8; i++) begin
            clk_bit(cmd[i], b, oh, ol);
            if (i < 7) any_oe = any_oe | oh | ol;
            else begin
                any_oe = any_oe | oh | ol;
                if (!ol) lo_bad = 1'b1;
                rbuf[0][0] = b;
            end
        end
        for (int k = 1; k < nbytes * 8; k++) begin
            clk_bit(1'b0, b, oh, ol);
            rbuf[k / 8][k % 8] = b;
            if (oh)  hi_bad = 1'b1;
            if (!ol) lo_bad = 1'b1;
            any_oe = any_oe | oh | ol;
        end
        ce_down();
    endtask

    task automatic do_write(input logic [7:0] cmd, input int nbytes, input int extra_bits);
        logic b, oh, ol;
        ce_up();
        for (int i = 0; i < 8; i++) clk_bit(cmd[i], b, oh, ol);
        for (int k = 0; k < nbytes * 8; k++) clk_bit(wbuf[k / 8][k % 8], b, oh, ol);
        for (int k = 0; k < extra_bits; k++) clk_bit(1'b1, b, oh, ol);
        ce_down();
    endtask

    task automatic t_reset();
        chk(io_oe == 1'b0, "R1 io_oe after reset", io_oe, 0);
        chk(wr_stb == 1'b0 && rd_stb == 1'b0, "R1 strobes after reset", {wr_stb, rd_stb}, 0);
    endtask

    task automatic t_single_clock();
        int w0;
        logic hb, lb, ao;
        w0 = wr_cnt;
        wbuf[0] = 8'h5A;
        do_write(mk_cmd(1'b0, 5'd3, 1'b0), 1, 0);
        exp_clk[3] = 8'h5A;
        chk(clk_m[3] == exp_clk[3], "R4 clock byte written", clk_m[3], exp_clk[3]);
        chk(wr_cnt - w0 == 1, "R4 one write strobe", wr_cnt - w0, 1);
        chk(ram_m[3] == exp_ram[3], "R2 RAM space untouched by clock write", ram_m[3], exp_ram[3]);
        do_read(mk_cmd(1'b0, 5'd3, 1'b1), 1, hb, lb, ao);
        chk(rbuf[0] == exp_clk[3], "R6 single read clock byte", rbuf[0], exp_clk[3]);
        chk(!hb, "R7 oe released in high phase", hb, 0);
        chk(!lb, "R7 oe set after falling edge", lb, 0);
        chk(io_oe == 1'b0, "R7 oe low after ce drops", io_oe, 0);
        do_read(mk_cmd(1'b1, 5'd3, 1'b1), 1, hb, lb, ao);
        chk(rbuf[0] == exp_ram[3], "R2 read selects RAM space", rbuf[0], exp_ram[3]);
    endtask

    task automatic t_write_extra();
        int w0;
        w0 = wr_cnt;
        wbuf[0] = 8'h3C;
        do_write(mk_cmd(1'b1, 5'd5, 1'b0), 1, 8);
        exp_ram[5] = 8'h3C;
        chk(wr_cnt - w0 == 1, "R5 extra clocks give no strobe", wr_cnt - w0, 1);
        chk(ram_m[5] == exp_ram[5], "R5 byte kept", ram_m[5], exp_ram[5]);
        chk(ram_m[6] == exp_ram[6], "R5 neighbour unchanged", ram_m[6], exp_ram[6]);
    endtask

    task automatic t_read_repeat();
        logic hb, lb, ao;
        do_read(mk_cmd(1'b1, 5'd5, 1'b1), 2, hb, lb, ao);
        chk(rbuf[0] == exp_ram[5], "R8 first byte", rbuf[0], exp_ram[5]);
        chk(rbuf[1] == exp_ram[5], "R8 extra clocks re-send same byte", rbuf[1], exp_ram[5]);
    endtask

    task automatic t_bad_cmd();
        int w0;
        logic hb, lb, ao;
        w0 = wr_cnt;
        wbuf[0] = 8'h11;
        do_write(8'h4A, 1, 0);
        chk(wr_cnt == w0, "R3 no write with bit7 clear", wr_cnt - w0, 0);
        chk(ram_m[5] == exp_ram[5], "R3 RAM unchanged", ram_m[5], exp_ram[5]);
        do_read(8'h4B, 2, hb, lb, ao);
        chk(!ao, "R3 never drives with bit7 clear", ao, 0);
    endtask

    task automatic t_burst_write_ram();
        int w0;
        w0 = wr_cnt;
        wbuf[0] = 8'hB0; wbuf[1] = 8'hB1; wbuf[2] = 8'hB2;
        do_write(mk_cmd(1'b1, 5'd31, 1'b0), 3, 0);
        for (int i = 0; i < 3; i++) exp_ram[i] = wbuf[i];
        chk(wr_cnt - w0 == 3, "R9 burst write strobes", wr_cnt - w0, 3);
        chk(ram_m[0] == 8'hB0 && ram_m[1] == 8'hB1 && ram_m[2] == 8'hB2,
            "R9 burst write from address 0", {ram_m[0], ram_m[1], ram_m[2]}, 24'hB0B1B2);
        chk(ram_m[3] == exp_ram[3], "R9 burst stops at last byte", ram_m[3], exp_ram[3]);
    endtask

    task automatic t_burst_read_ram();
        logic hb, lb, ao;
        int bad;
        bad = 0;
        do_read(mk_cmd(1'b1, 5'd31, 1'b1), 32, hb, lb, ao);
        for (int i = 0; i < 31; i++) if (rbuf[i] != exp_ram[i]) bad++;
        chk(bad == 0, "R9 RAM burst read bytes 0..30", bad, 0);
        chk(rbuf[31] == exp_ram[0], "R10 RAM burst wraps after 30", rbuf[31], exp_ram[0]);
        chk(!hb && !lb, "R7 oe pattern over long burst", {hb, lb}, 0);
    endtask

    task automatic t_burst_clock();
        logic hb, lb, ao;
        int bad;
        bad = 0;
        for (int i = 0; i < 9; i++) wbuf[i] = 8'h40 + 8'(i);
        do_write(mk_cmd(1'b0, 5'd31, 1'b0), 9, 0);
        for (int i = 1; i < 8; i++) exp_clk[i] = wbuf[i];
        exp_clk[0] = wbuf[8];
        chk(clk_m[0] == exp_clk[0], "R10 clock burst write wraps after 7", clk_m[0], exp_clk[0]);
        chk(clk_m[8] == exp_clk[8], "R10 clock burst never reaches 8", clk_m[8], exp_clk[8]);
        do_read(mk_cmd(1'b0, 5'd31, 1'b1), 9, hb, lb, ao);
        for (int i = 0; i < 8; i++) if (rbuf[i] != exp_clk[i]) bad++;
        chk(bad == 0, "R9 clock burst read bytes 0..7", bad, 0);
        chk(rbuf[8] == exp_clk[0], "R10 clock burst read wraps", rbuf[8], exp_clk[0]);
    endtask

    task automatic t_abort();
        int w0;
        logic b, oh, ol, hb, lb, ao;
        logic [7:0] cmd;
        w0 = wr_cnt;
        cmd = mk_cmd(1'b0, 5'd6, 1'b0);
        ce_up();
        for (int i = 0; i < 8; i++) clk_bit(cmd[i], b, oh, ol);
        for (int i = 0; i < 4; i++) clk_bit(1'b1, b, oh, ol);
        ce_down();
        chk(wr_cnt == w0, "R11 aborted write gives no strobe", wr_cnt - w0, 0);
        chk(clk_m[6] == exp_clk[6], "R11 target unchanged", clk_m[6], exp_clk[6]);
        do_read(mk_cmd(1'b0, 5'd6, 1'b1), 1, hb, lb, ao);
        chk(rbuf[0] == exp_clk[6], "R11 next transfer after abort", rbuf[0], exp_clk[6]);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            exp_clk[i] = 8'h20 + 8'(i);
            exp_ram[i] = 8'h80 + 8'(3 * i);
        end
        #100ns;
        rst_n = 1'b1;
        #100ns;
        t_reset();
        t_single_clock();
        t_write_extra();
        t_read_repeat();
        t_bad_cmd();
        t_burst_write_ram();
        t_burst_read_ram();
        t_burst_clock();
        t_abort();
        chk(strobe_bad == 0, "R12 strobe pulses single and exclusive", strobe_bad, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule